// File: doc/BRIEF.md
# Clock Generator Configuration Slave (SMBus)

This block is the serial configuration port of a clock generator. It sits on a two-wire SMBus segment as a slave. It samples SCL and SDA with the system clock, finds start and stop conditions, shifts bytes in and out most significant bit first, and pulls SDA low to acknowledge. Behind the port sits a bank of eight 8-bit registers. Their bits drive the output enables, the spread-spectrum controls and the test-clock controls of the generator. The last register is a fixed identity byte.

After the address byte, the master sends a command byte. A set top bit selects indexed single-byte access, with the register index taken from the low five bits. A clear top bit selects sequential block access, which starts at register 0 and carries a byte count. Two command bits act as a chip-select field. Any value other than zero in that field makes the slave refuse the command. Reads use a repeated start followed by the read-form address. A block read returns a count byte before the data.

Top module: `smb_clkcfg`

## Requirements
- R1: After reset, registers 0 to 7 read 7Ch, 00h, EBh, AFh, 01h, 00h, 13h and 38h.
- R2: The slave acknowledges only the address byte D2h (7-bit address 69h with write bit 0) or D3h (read bit 1). Any other address gets no acknowledge, and the rest of that transfer changes nothing.
- R3: A byte write (command bit 7 = 1, bits 6:5 = 00, bits 4:0 = index) acknowledges the address, the command and one data byte. It stores the data byte in the indexed register.
- R4: A byte read sends a byte write's address and command, then a repeated start and D3h. It returns the indexed register's value.
- R5: A block write (command 00h) acknowledges a count byte and then each data byte. Data bytes go into registers 0, 1, 2 and upward in turn. A stop after any complete byte keeps every byte acknowledged so far.
- R6: A block read (command 00h, repeated start, D3h) first returns the count 08h and then registers 0 upward. Any index beyond 7 reads 00h.
- R7: A command byte whose bits 6:5 are not 00 gets no acknowledge. The transfer then changes no register.
- R8: Register 7 is read-only and reads 38h: revision code 3 in bits 7:4 and vendor code 8 in bits 3:0. A write to it is acknowledged and has no effect. Writes to indexes 8 to 31 are also acknowledged and have no effect. Reads of those indexes return 00h.
- R9: The output enables are register 0 bits 6:2, with out_en[4] taken from bit 6. spread_wide is register 2 bit 7 (1 = -0.50%, 0 = -0.35%). spread_on is register 2 bit 2. test_ref is register 6 bit 7. test_en is register 6 bit 6.
- R10: A stop or start in the middle of a byte abandons that byte without a register write, and the slave releases SDA.
- R11: In byte mode, a second data byte in the same transfer gets no acknowledge and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, restores the power-up register values |
| scl_in | input | 1 | SCL level seen at the pin |
| sda_in | input | 1 | SDA level seen at the pin (wired-AND of all drivers) |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| out_en | output | 5 | Per-output enables, 1 = driving, 0 = Hi-Z |
| spread_wide | output | 1 | Spread depth select |
| spread_on | output | 1 | Spread enable |
| test_ref | output | 1 | Test mode: 1 = REF/N clock, 0 = tri-state |
| test_en | output | 1 | Test-clock mode entry |

## Verification
Each bus edge passes through a two-flop synchroniser and one state register, so the slave moves SDA and updates a register three system clocks after the SCL edge that causes it. The bench master holds every SCL half-level for ten clocks. It drives SDA a quarter period after SCL falls and samples it a quarter period after SCL rises, so every acknowledge and read bit has settled for at least two clocks. The control outputs are compared only after the stop that ends a write, well past their three-cycle update.

// File: rtl/smb_clkcfg.sv
module smb_clkcfg #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [3:0] REV_CODE    = 4'h3,
  parameter logic [3:0] VENDOR_CODE = 4'h8,
  parameter int         NREGS       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [4:0] out_en,
  output logic       spread_wide,
  output logic       spread_on,
  output logic       test_ref,
  output logic       test_en
);
  localparam int   RW = NREGS - 1;
  localparam logic [7:0] BLK_COUNT = 8'(NREGS);
  localparam logic [4:0] RO_IDX    = 5'(RW);

  typedef enum logic [2:0] {IDLE, ADDR, CMD, COUNT, WDATA, RDATA} phase_t;

  function automatic logic [7:0] init_val(input int i);
    case (i)
      0: return 8'h7C;
      2: return 8'hEB;
      3: return 8'hAF;
      4: return 8'h01;
      6: return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

  logic [2:0] scl_q, sda_q;
  phase_t     phase, nxt;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       in_ack, mode_byte, byte_done, cnt_pend;
  logic [4:0] ptr, ptr_nx;
  logic       cnt_nx;
  logic [7:0] rd_data;
  logic [7:0] rf [0:RW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire idle      = (phase == IDLE);
  wire byte_end  = scl_fall && !in_ack && bitcnt == 4'd8;
  wire wr_en     = !start_det && !stop_det && byte_end && phase == WDATA
                   && !(mode_byte && byte_done);

  function automatic logic [7:0] reg_at(input logic [4:0] p);
    if (p == RO_IDX)    return {REV_CODE, VENDOR_CODE};
    else if (p < RO_IDX) return rf[p[2:0]];
    else                return 8'h00;
  endfunction

  always_comb begin
    ptr_nx = ptr;
    cnt_nx = cnt_pend;
    if (phase == RDATA) begin
      if (cnt_pend) cnt_nx = 1'b0;
      else if (!mode_byte && ptr != 5'd31) ptr_nx = ptr + 5'd1;
    end
    rd_data = cnt_nx ? BLK_COUNT : reg_at(ptr_nx);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= IDLE;
      nxt       <= IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      in_ack    <= 1'b0;
      sda_pull  <= 1'b0;
      mode_byte <= 1'b0;
      byte_done <= 1'b0;
      cnt_pend  <= 1'b0;
      ptr       <= '0;
    end else if (start_det) begin
      phase    <= ADDR;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      phase    <= IDLE;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (!idle) begin
      if (scl_rise) begin
        if (!in_ack) begin
          bitcnt <= bitcnt + 4'd1;
          if (phase != RDATA) sh <= {sh[6:0], sda_q[1]};
        end else if (phase == RDATA && sda_q[1]) begin
          phase  <= IDLE;
          in_ack <= 1'b0;
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          phase  <= nxt;
          if (nxt == RDATA) begin
            ptr      <= ptr_nx;
            cnt_pend <= cnt_nx;
            sh       <= rd_data;
            sda_pull <= ~rd_data[7];
          end else begin
            sda_pull <= 1'b0;
          end
        end else if (phase == RDATA) begin
          if (bitcnt == 4'd8) begin
            in_ack   <= 1'b1;
            sda_pull <= 1'b0;
            nxt      <= RDATA;
          end else begin
            sh       <= {sh[6:0], 1'b0};
            sda_pull <= ~sh[6];
          end
        end else if (bitcnt == 4'd8) begin
          in_ack   <= 1'b1;
          sda_pull <= 1'b1;
          case (phase)
            ADDR:
              if (sh[7:1] != DEV_ADDR) begin
                phase <= IDLE; in_ack <= 1'b0; sda_pull <= 1'b0;
              end else if (sh[0]) begin
                nxt      <= RDATA;
                cnt_pend <= !mode_byte;
              end else begin
                nxt <= CMD;
              end
            CMD:
              if (sh[6:5] != 2'b00) begin
                phase <= IDLE; in_ack <= 1'b0; sda_pull <= 1'b0;
              end else begin
                mode_byte <= sh[7];
                ptr       <= sh[7] ? sh[4:0] : 5'd0;
                byte_done <= 1'b0;
                nxt       <= sh[7] ? WDATA : COUNT;
              end
            COUNT: nxt <= WDATA;
            WDATA:
              if (mode_byte && byte_done) begin
                phase <= IDLE; in_ack <= 1'b0; sda_pull <= 1'b0;
              end else begin
                byte_done <= 1'b1;
                nxt       <= WDATA;
                if (!mode_byte && ptr != 5'd31) ptr <= ptr + 5'd1;
              end
            default: begin
              phase <= IDLE; in_ack <= 1'b0; sda_pull <= 1'b0;
            end
          endcase
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < RW; i++) rf[i] <= init_val(i);
    end else if (wr_en && ptr < RO_IDX) begin
      rf[ptr[2:0]] <= sh;
    end

  assign out_en      = rf[0][6:2];
  assign spread_wide = rf[2][7];
  assign spread_on   = rf[2][2];
  assign test_ref    = rf[6][7];
  assign test_en     = rf[6][6];
endmodule

// File: rtl/smb_clkcfg_chk.sv
module smb_clkcfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic       idle,
  input logic [8:0] ctl
);
  // R2: with no transfer in progress the slave never holds SDA
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull);

  // R4 / R6: data and acknowledge move only on SCL low or a bus condition
  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));

  // R9: control outputs change only right after a committed data byte
  a_r9_ctl_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl) |-> $past(wr_en));

  // R10: a stop always releases the bus
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
endmodule

bind smb_clkcfg smb_clkcfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en), .idle(idle),
  .ctl({out_en, spread_wide, spread_on, test_ref, test_en})
);

// File: tb/smb_clkcfg_test.sv
module smb_clkcfg_test;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, spread_wide, spread_on, test_ref, test_en;
  logic [4:0] out_en;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mdl [0:7];
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];

  always #10 clk = ~clk;

  smb_clkcfg uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .out_en(out_en), .spread_wide(spread_wide),
    .spread_on(spread_on), .test_ref(test_ref), .test_en(test_en));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    return (i < 8) ? mdl[i] : 8'h00;
  endfunction

  function automatic logic [8:0] exp_ctl();
    return {mdl[0][6:2], mdl[2][7], mdl[2][2], mdl[6][7], mdl[6][6]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = !sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0;
    end
    tick(Q); sda_m = !mack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); sda_m = 1;
  endtask

  task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d, output bit [2:0] a);
    bus_start(); send(8'hD2, a[0]); send(cmd, a[1]); send(d, a[2]); bus_stop();
  endtask

  task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d, output bit [2:0] a);
    bus_start(); send(8'hD2, a[0]); send(cmd, a[1]);
    bus_start(); send(8'hD3, a[2]); recv(0, d); bus_stop();
  endtask

  task automatic blk_write(input int n, output int nacks);
    bit a;
    nacks = 0;
    bus_start(); send(8'hD2, a); nacks += !a; send(8'h00, a); nacks += !a;
    send(8'(n), a); nacks += !a;
    for (int i = 0; i < n; i++) begin send(wbuf[i], a); nacks += !a; end
    bus_stop();
  endtask

  task automatic blk_read(input int n, output logic [7:0] cnt);
    bit a;
    bus_start(); send(8'hD2, a); send(8'h00, a); bus_start(); send(8'hD3, a);
    recv(1, cnt);
    for (int i = 0; i < n; i++) recv(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic check_all_regs(input string tag);
    logic [7:0] c;
    blk_read(10, c);
    check(c == 8'h08, {tag, " count"}, c, 8);
    for (int i = 0; i < 10; i++)
      check(rbuf[i] == exp_byte(i), tag, rbuf[i], exp_byte(i));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [2:0] a;
    logic [7:0] d;
    int nk;
    void'($urandom(32'd1234));
    mdl[0] = 8'h7C; mdl[1] = 8'h00; mdl[2] = 8'hEB; mdl[3] = 8'hAF;
    mdl[4] = 8'h01; mdl[5] = 8'h00; mdl[6] = 8'h13; mdl[7] = 8'h38;
    tick(5); rst_n = 1; tick(5);

    check({out_en, spread_wide, spread_on, test_ref, test_en} == exp_ctl(), "R1/R9 reset outputs",
          {out_en, spread_wide, spread_on, test_ref, test_en}, exp_ctl());
    check(sda_pull == 0, "R1 bus released", sda_pull, 0);
    check_all_regs("R1/R6 reset block read");

    // R2: foreign address
    bus_start(); send(8'hD4, a[0]); send(8'h81, a[1]); send(8'h5A, a[2]); bus_stop();
    check(a[0] == 0, "R2 foreign address ack", a[0], 0);
    byte_read(8'h81, d, a);
    check(d == 8'h00, "R2 foreign write ignored", d, 0);
    check(a == 3'b111, "R2 own address acks", a, 7);

    // R3 / R9: byte write to register 0
    byte_write(8'h80, 8'h40, a); mdl[0] = 8'h40;
    check(a == 3'b111, "R3 byte write acks", a, 7);
    check(out_en == 5'b10000, "R9 out_en", out_en, 5'b10000);
    byte_read(8'h80, d, a);
    check(d == 8'h40, "R4 byte read", d, 8'h40);

    // R7: chip-select field non-zero
    byte_write(8'hA2, 8'h00, a);
    check(a[1] == 0, "R7 command nack", a[1], 0);
    byte_read(8'h82, d, a);
    check(d == 8'hEB, "R7 register unchanged", d, 8'hEB);

    // R8: read-only identity and out-of-range index
    byte_write(8'h87, 8'hFF, a);
    check(a == 3'b111, "R8 write to identity acked", a, 7);
    byte_read(8'h87, d, a);
    check(d == 8'h38, "R8 identity byte", d, 8'h38);
    byte_write(8'h89, 8'h77, a);
    check(a == 3'b111, "R8 out-of-range write acked", a, 7);
    byte_read(8'h89, d, a);
    check(d == 8'h00, "R8 out-of-range read", d, 0);

    // R11: second data byte in byte mode
    bus_start(); send(8'hD2, a[0]); send(8'h83, a[1]); send(8'h5C, a[2]);
    send(8'h99, a[0]); bus_stop(); mdl[3] = 8'h5C;
    check(a[2] == 1 && a[0] == 0, "R11 second byte nack", {a[2], a[0]}, 2);
    byte_read(8'h83, d, a);
    check(d == 8'h5C, "R11 first byte kept", d, 8'h5C);
    byte_read(8'h84, d, a);
    check(d == mdl[4], "R11 next register untouched", d, mdl[4]);

    // R10: stop in the middle of a data byte
    bus_start(); send(8'hD2, a[0]); send(8'h85, a[1]); send_bits(8'hF0, 4); bus_stop();
    check(sda_pull == 0, "R10 bus released", sda_pull, 0);
    byte_read(8'h85, d, a);
    check(d == 8'h00, "R10 partial byte dropped", d, 0);

    // R5: block write stopped after three bytes
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA5; wbuf[2] = 8'h04;
    blk_write(3, nk);
    for (int i = 0; i < 3; i++) mdl[i] = wbuf[i];
    check(nk == 0, "R5 block write acks", nk, 0);
    check({out_en, spread_wide, spread_on, test_ref, test_en} == exp_ctl(), "R9 after block write",
          {out_en, spread_wide, spread_on, test_ref, test_en}, exp_ctl());
    check_all_regs("R5/R6 short block write");

    // random byte traffic
    for (int it = 0; it < 30; it++) begin
      int off = int'($urandom_range(0, 9));
      logic [7:0] v = 8'($urandom);
      int roff = int'($urandom_range(0, 9));
      byte_write({3'b100, 5'(off)}, v, a);
      if (off < 7) mdl[off] = v;
      check(a == 3'b111, "R3 random write acks", a, 7);
      byte_read({3'b100, 5'(roff)}, d, a);
      check(d == exp_byte(roff), "R4 random read", d, exp_byte(roff));
      check({out_en, spread_wide, spread_on, test_ref, test_en} == exp_ctl(), "R9 random outputs",
            {out_en, spread_wide, spread_on, test_ref, test_en}, exp_ctl());
    end

    // random block traffic
    for (int it = 0; it < 8; it++) begin
      int n = int'($urandom_range(1, 9));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      blk_write(n, nk);
      for (int i = 0; i < n && i < 7; i++) mdl[i] = wbuf[i];
      check(nk == 0, "R5 random block write acks", nk, 0);
      check_all_regs("R6 random block read");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule